// File: doc/BRIEF.md
# Power-Scheduled Minimum-Pulse Limit Generator

This block sets the minimum-pulse threshold that a space-vector modulator applies to its three duty cycles. It watches the rotating-frame stator currents and voltages at every control sample and forms the active-power term `id*vd + iq*vq`. It adds that term up over a fixed window of samples. At the end of each window it scales the sum to a per-unit power and evaluates a third-order polynomial in that power. The result is published as the new limit. Between windows the output holds its last value, so the modulator sees a threshold that changes only slowly and does not upset the current loops.

The scale input folds the 3/2 factor of the power formula, the window length and the reciprocal of the base power into one unsigned number. The base power is the input power at nominal torque and reference speed. The polynomial runs in Horner form on one shared shift-and-add multiplier, so a window result reaches the output a few tens of cycles after the window closes. That is far shorter than one sample interval.

Top module: `plc_pulse_limit`

## Requirements
- R1: From reset until the first window result is published, `d_limit_o` is 0 and `d_limit_vld_o` is low.
- R2: Only cycles with `smp_stb_i` high add to the window sum. The sum S is the signed total of `id_i*vd_i + iq_i*vq_i` over those samples. Input values on other cycles have no effect on the result.
- R3: A window is exactly `WIN_SAMPLES` strobes (default 2500). No result is published before the window's last strobe. The sum restarts from zero for the next window, so each result depends only on its own window.
- R4: Per-unit power p is an unsigned Q2.14 value: p = min(floor(S * `pu_scale_i` / 2^32), 65535). `pu_scale_i` is taken on the window's last strobe.
- R5: With a Q14 floor shift written `>>>14`, the limit is y = (t2*p)>>>14. Here t2 = ((t1*p)>>>14) + 4717 and t1 = ((1327*p)>>>14) - 4053. These coefficients are the Q14 forms of 0.2879, -0.2474 and 0.08102, the fractional limit per unit power.
- R6: When S is zero or negative, the published limit is 0.
- R7: The output is unsigned Q0.16. If y <= 0 it is 0. If y >= 8192 (one half) it is 32768. Otherwise it is 4*y. It never exceeds 32768.
- R8: `d_limit_vld_o` is a single-cycle pulse, one per window. `d_limit_o` changes only in a pulse cycle and holds otherwise.
- R9: The pulse arrives within 80 clock cycles after the edge that takes the window's last strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_stb_i | input | 1 | Control-sample strobe |
| id_i | input | 16 | Direct-axis current, signed |
| iq_i | input | 16 | Quadrature-axis current, signed |
| vd_i | input | 16 | Direct-axis voltage, signed |
| vq_i | input | 16 | Quadrature-axis voltage, signed |
| pu_scale_i | input | 16 | Unsigned per-unit scale (3/2, window length and base reciprocal combined) |
| d_limit_o | output | 16 | Minimum-pulse limit, unsigned Q0.16 |
| d_limit_vld_o | output | 1 | One-cycle pulse marking a new limit |

## Verification
The hardest state to reach from the ports is the end of a full 2500-sample window. Every result depends on the whole window sum, so the stimulus has to drive complete windows. Between strobes it drives extreme garbage values, which shows that non-strobe cycles are ignored. Varying ramp samples make sure the sum is not just a count times one term. Back-to-back windows with very different power show that the sum is cleared. Corner windows cover both output clamps, the saturation of the per-unit value, a positive sum that rounds to zero power, and a negative sum.

// File: rtl/plc_pkg.sv
package plc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_NORM,
    ST_CUBE,
    ST_QUAD,
    ST_LIN
  } plc_state_e;
endpackage

// File: rtl/plc_seq_mul.sv
module plc_seq_mul #(
  parameter int AW = 45,
  parameter int BW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic signed [AW-1:0] a_i,
  input  logic [BW-1:0]        b_i,
  output logic                 done_o,
  output logic signed [AW+BW-1:0] prod_o
);
  localparam int PW = AW + BW;
  localparam int CW = $clog2(BW + 1);

  logic signed [PW-1:0] mcand_q, mcand_nxt, prod_q, prod_nxt;
  logic [BW-1:0]        mplr_q, mplr_nxt;
  logic [CW-1:0]        cnt_q, cnt_nxt;
  logic                 busy_q, busy_nxt, done_q, done_nxt;
  logic                 dp_en;

  assign dp_en = start_i | busy_q;

  always_comb begin
    mcand_nxt = mcand_q;
    prod_nxt  = prod_q;
    mplr_nxt  = mplr_q;
    cnt_nxt   = cnt_q;
    busy_nxt  = busy_q;
    done_nxt  = 1'b0;
    if (start_i) begin
      mcand_nxt = a_i;
      mplr_nxt  = b_i;
      prod_nxt  = '0;
      cnt_nxt   = '0;
      busy_nxt  = 1'b1;
    end else if (busy_q) begin
      if (mplr_q[0]) prod_nxt = prod_q + mcand_q;
      mcand_nxt = mcand_q <<< 1;
      mplr_nxt  = mplr_q >> 1;
      cnt_nxt   = cnt_q + 1'b1;
      if (cnt_q == CW'(BW - 1)) begin
        busy_nxt = 1'b0;
        done_nxt = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      prod_q  <= '0;
      mplr_q  <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      busy_q <= busy_nxt;
      done_q <= done_nxt;
      if (dp_en) begin
        mcand_q <= mcand_nxt;
        prod_q  <= prod_nxt;
        mplr_q  <= mplr_nxt;
        cnt_q   <= cnt_nxt;
      end
    end
  end

  assign done_o = done_q;
  assign prod_o = prod_q;
endmodule

// File: rtl/plc_power_acc.sv
module plc_power_acc #(
  parameter int SIG_W       = 16,
  parameter int SCL_W       = 16,
  parameter int WIN_SAMPLES = 2500,
  parameter int ACC_W       = 45
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    stb_i,
  input  logic signed [SIG_W-1:0] id_i,
  input  logic signed [SIG_W-1:0] iq_i,
  input  logic signed [SIG_W-1:0] vd_i,
  input  logic signed [SIG_W-1:0] vq_i,
  input  logic [SCL_W-1:0]        scale_i,
  output logic                    win_done_o,
  output logic signed [ACC_W-1:0] win_sum_o,
  output logic [SCL_W-1:0]        win_scale_o
);
  localparam int CNT_W = $clog2(WIN_SAMPLES);
  localparam int TRM_W = 2 * SIG_W + 1;

  logic signed [TRM_W-1:0] term;
  logic signed [ACC_W-1:0] term_ext;
  logic signed [ACC_W-1:0] acc_q, acc_nxt, sum_q, sum_nxt;
  logic [CNT_W-1:0]        cnt_q, cnt_nxt;
  logic [SCL_W-1:0]        scl_q, scl_nxt;
  logic                    done_q, done_nxt;
  logic                    last;

  assign term     = TRM_W'(id_i * vd_i) + TRM_W'(iq_i * vq_i);
  assign term_ext = ACC_W'(term);
  assign last     = (cnt_q == CNT_W'(WIN_SAMPLES - 1));

  always_comb begin
    acc_nxt  = acc_q;
    cnt_nxt  = cnt_q;
    sum_nxt  = sum_q;
    scl_nxt  = scl_q;
    done_nxt = 1'b0;
    if (stb_i) begin
      if (last) begin
        sum_nxt  = acc_q + term_ext;
        scl_nxt  = scale_i;
        acc_nxt  = '0;
        cnt_nxt  = '0;
        done_nxt = 1'b1;
      end else begin
        acc_nxt = acc_q + term_ext;
        cnt_nxt = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      cnt_q  <= '0;
      sum_q  <= '0;
      scl_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_nxt;
      if (stb_i) begin
        acc_q <= acc_nxt;
        cnt_q <= cnt_nxt;
        sum_q <= sum_nxt;
        scl_q <= scl_nxt;
      end
    end
  end

  assign win_done_o  = done_q;
  assign win_sum_o   = sum_q;
  assign win_scale_o = scl_q;
endmodule

// File: rtl/plc_poly_eval.sv
module plc_poly_eval
  import plc_pkg::*;
#(
  parameter int ACC_W   = 45,
  parameter int PU_W    = 16,
  parameter int OUT_W   = 16,
  parameter int FRAC    = 14,
  parameter int NORM_SH = 32,
  parameter int C1      = 4717,
  parameter int C2      = -4053,
  parameter int C3      = 1327
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         win_done_i,
  input  logic signed [ACC_W-1:0]      win_sum_i,
  input  logic [PU_W-1:0]              win_scale_i,
  input  logic                         mul_done_i,
  input  logic signed [ACC_W+PU_W-1:0] mul_prod_i,
  output logic                         mul_start_o,
  output logic signed [ACC_W-1:0]      mul_a_o,
  output logic [PU_W-1:0]              mul_b_o,
  output logic [OUT_W-1:0]             d_limit_o,
  output logic                         vld_o
);
  localparam int PROD_W = ACC_W + PU_W;
  localparam logic signed [ACC_W-1:0] C1_EXT   = ACC_W'(C1);
  localparam logic signed [ACC_W-1:0] C2_EXT   = ACC_W'(C2);
  localparam logic signed [ACC_W-1:0] C3_EXT   = ACC_W'(C3);
  localparam logic signed [ACC_W-1:0] HALF_EXT = ACC_W'(2 ** (FRAC - 1));
  localparam logic [OUT_W-1:0]        OUT_CAP  = OUT_W'(2 ** (OUT_W - 1));
  localparam int OS = OUT_W - FRAC;

  plc_state_e st_q, st_nxt;
  logic [PU_W-1:0]          p_q, p_nxt, p_sat;
  logic [OUT_W-1:0]         d_q, d_nxt, d_clamped;
  logic                     vld_q, vld_nxt;
  logic signed [PROD_W-1:0] sh_frac, sh_norm;
  logic signed [ACC_W-1:0]  hv;
  logic                     sum_nonpos;

  assign sh_frac    = mul_prod_i >>> FRAC;
  assign sh_norm    = mul_prod_i >>> NORM_SH;
  assign hv         = sh_frac[ACC_W-1:0];
  assign p_sat      = (|sh_norm[PROD_W-1:PU_W]) ? {PU_W{1'b1}} : sh_norm[PU_W-1:0];
  assign sum_nonpos = win_sum_i[ACC_W-1] || (win_sum_i == '0);

  always_comb begin
    if (hv[ACC_W-1] || hv == '0)  d_clamped = '0;
    else if (hv >= HALF_EXT)      d_clamped = OUT_CAP;
    else                          d_clamped = OUT_W'(hv[FRAC-1:0]) << OS;
  end

  always_comb begin
    st_nxt      = st_q;
    p_nxt       = p_q;
    d_nxt       = d_q;
    vld_nxt     = 1'b0;
    mul_start_o = 1'b0;
    mul_a_o     = '0;
    mul_b_o     = p_q;
    unique case (st_q)
      ST_IDLE: if (win_done_i) begin
        if (sum_nonpos) begin
          d_nxt   = '0;
          vld_nxt = 1'b1;
        end else begin
          mul_start_o = 1'b1;
          mul_a_o     = win_sum_i;
          mul_b_o     = win_scale_i;
          st_nxt      = ST_NORM;
        end
      end
      ST_NORM: if (mul_done_i) begin
        p_nxt       = p_sat;
        mul_start_o = 1'b1;
        mul_a_o     = C3_EXT;
        mul_b_o     = p_sat;
        st_nxt      = ST_CUBE;
      end
      ST_CUBE: if (mul_done_i) begin
        mul_start_o = 1'b1;
        mul_a_o     = hv + C2_EXT;
        st_nxt      = ST_QUAD;
      end
      ST_QUAD: if (mul_done_i) begin
        mul_start_o = 1'b1;
        mul_a_o     = hv + C1_EXT;
        st_nxt      = ST_LIN;
      end
      ST_LIN: if (mul_done_i) begin
        d_nxt   = d_clamped;
        vld_nxt = 1'b1;
        st_nxt  = ST_IDLE;
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      p_q   <= '0;
      d_q   <= '0;
      vld_q <= 1'b0;
    end else begin
      st_q  <= st_nxt;
      vld_q <= vld_nxt;
      p_q   <= p_nxt;
      if (vld_nxt) d_q <= d_nxt;
    end
  end

  assign d_limit_o = d_q;
  assign vld_o     = vld_q;
endmodule

// File: rtl/plc_pulse_limit.sv
module plc_pulse_limit #(
  parameter int SIG_W       = 16,
  parameter int SCL_W       = 16,
  parameter int OUT_W       = 16,
  parameter int FRAC        = 14,
  parameter int NORM_SH     = 32,
  parameter int WIN_SAMPLES = 2500,
  parameter int C1          = 4717,
  parameter int C2          = -4053,
  parameter int C3          = 1327
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_stb_i,
  input  logic signed [SIG_W-1:0] id_i,
  input  logic signed [SIG_W-1:0] iq_i,
  input  logic signed [SIG_W-1:0] vd_i,
  input  logic signed [SIG_W-1:0] vq_i,
  input  logic [SCL_W-1:0]        pu_scale_i,
  output logic [OUT_W-1:0]        d_limit_o,
  output logic                    d_limit_vld_o
);
  localparam int ACC_W  = 2 * SIG_W + 1 + $clog2(WIN_SAMPLES + 1);
  localparam int PROD_W = ACC_W + SCL_W;

  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  logic                     win_done;
  logic signed [ACC_W-1:0]  win_sum;
  logic [SCL_W-1:0]         win_scale;
  logic                     mul_start, mul_done;
  logic signed [ACC_W-1:0]  mul_a;
  logic [SCL_W-1:0]         mul_b;
  logic signed [PROD_W-1:0] mul_prod;

  plc_power_acc #(
    .SIG_W(SIG_W), .SCL_W(SCL_W), .WIN_SAMPLES(WIN_SAMPLES), .ACC_W(ACC_W)
  ) u_acc (
    .clk(clk), .rst_n(rst_sync_n), .stb_i(smp_stb_i),
    .id_i(id_i), .iq_i(iq_i), .vd_i(vd_i), .vq_i(vq_i),
    .scale_i(pu_scale_i),
    .win_done_o(win_done), .win_sum_o(win_sum), .win_scale_o(win_scale)
  );

  plc_seq_mul #(.AW(ACC_W), .BW(SCL_W)) u_mul (
    .clk(clk), .rst_n(rst_sync_n), .start_i(mul_start),
    .a_i(mul_a), .b_i(mul_b), .done_o(mul_done), .prod_o(mul_prod)
  );

  plc_poly_eval #(
    .ACC_W(ACC_W), .PU_W(SCL_W), .OUT_W(OUT_W), .FRAC(FRAC),
    .NORM_SH(NORM_SH), .C1(C1), .C2(C2), .C3(C3)
  ) u_poly (
    .clk(clk), .rst_n(rst_sync_n),
    .win_done_i(win_done), .win_sum_i(win_sum), .win_scale_i(win_scale),
    .mul_done_i(mul_done), .mul_prod_i(mul_prod),
    .mul_start_o(mul_start), .mul_a_o(mul_a), .mul_b_o(mul_b),
    .d_limit_o(d_limit_o), .vld_o(d_limit_vld_o)
  );
endmodule

// File: rtl/plc_pulse_limit_chk.sv
module plc_pulse_limit_chk #(
  parameter int WIN_SAMPLES = 2500,
  parameter int OUT_W       = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stb,
  input logic [OUT_W-1:0] d_limit,
  input logic             vld
);
  localparam int CNT_W = $clog2(WIN_SAMPLES);
  localparam logic [OUT_W-1:0] CAP = OUT_W'(2 ** (OUT_W - 1));

  logic [CNT_W-1:0] cnt_q;
  logic             pend_q, seen_q;
  logic [7:0]       lat_q;
  logic             close;

  assign close = stb && (cnt_q == CNT_W'(WIN_SAMPLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      seen_q <= 1'b0;
      lat_q  <= '0;
    end else begin
      if (stb) cnt_q <= close ? '0 : cnt_q + 1'b1;
      if (close)    pend_q <= 1'b1;
      else if (vld) pend_q <= 1'b0;
      if (close)                 lat_q <= '0;
      else if (lat_q != 8'hFF)   lat_q <= lat_q + 1'b1;
      if (vld) seen_q <= 1'b1;
    end
  end

  AST_ZERO_BEFORE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen_q && !vld) |-> d_limit == '0);  // R1
  AST_PULSE_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> pend_q);  // R3
  AST_OUT_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    d_limit <= CAP);  // R7
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    vld |=> !vld);  // R8
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |-> $stable(d_limit));  // R8
  AST_LATENCY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> lat_q <= 8'd80);  // R9
endmodule

bind plc_pulse_limit plc_pulse_limit_chk #(
  .WIN_SAMPLES(WIN_SAMPLES), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .stb(smp_stb_i),
  .d_limit(d_limit_o), .vld(d_limit_vld_o)
);

// File: tb/tb_plc_pulse_limit.sv
`timescale 1ns/1ps
module tb_plc_pulse_limit;
  localparam int WIN = 2500;

  logic clk = 1'b0;
  logic rst_n;
  logic smp_stb_i;
  logic signed [15:0] id_i, iq_i, vd_i, vq_i;
  logic [15:0] pu_scale_i;
  logic [15:0] d_limit_o;
  logic d_limit_vld_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  plc_pulse_limit dut (
    .clk(clk), .rst_n(rst_n), .smp_stb_i(smp_stb_i),
    .id_i(id_i), .iq_i(iq_i), .vd_i(vd_i), .vq_i(vq_i),
    .pu_scale_i(pu_scale_i),
    .d_limit_o(d_limit_o), .d_limit_vld_o(d_limit_vld_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected limit from R4, R5, R6 and R7
  function automatic longint model(input longint s, input longint scale);
    longint p, t, y;
    if (s <= 0) return 0;
    p = (s * scale) >>> 32;
    if (p > 65535) p = 65535;
    t = ((1327 * p) >>> 14) - 4053;
    t = ((t * p) >>> 14) + 4717;
    y = (t * p) >>> 14;
    if (y <= 0) return 0;
    if (y >= 8192) return 32768;
    return y * 4;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    check(d_limit_o == 16'd0, "R1 reset limit", d_limit_o, 0);
    check(d_limit_vld_o == 1'b0, "R1 reset valid", d_limit_vld_o, 0);
  endtask

  // mode 0: constant samples; mode 1: ramped id and vq
  task automatic run_window(input int mode, input int a, input int b, input int c,
                            input int d, input int scale, input string tag);
    longint s = 0;
    longint exp_v;
    int early = 0;
    int lat = 0;
    logic [15:0] prev = d_limit_o;
    logic [15:0] got;
    for (int i = 0; i < WIN; i++) begin
      int ia = (mode == 1) ? a + 3 * i : a;
      int vb = b;
      int ic = c;
      int vd = (mode == 1) ? d - i : d;
      @(negedge clk);
      if (d_limit_vld_o || d_limit_o != prev) early++;
      smp_stb_i = 1'b1;
      id_i = 16'(ia); vd_i = 16'(vb); iq_i = 16'(ic); vq_i = 16'(vd);
      pu_scale_i = 16'(scale);
      s += longint'(ia) * longint'(vb) + longint'(ic) * longint'(vd);
      @(negedge clk);
      if (d_limit_vld_o || d_limit_o != prev) early++;
      smp_stb_i = 1'b0;
      id_i = -16'sd32768; vd_i = -16'sd32768; iq_i = 16'sh7fff; vq_i = -16'sd32768;
      pu_scale_i = 16'hffff;
    end
    // R2 and R3: no output change during the window, garbage between strobes ignored
    check(early == 0, {"R3 no early update ", tag}, early, 0);
    while (!d_limit_vld_o && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    check(lat <= 80, {"R9 latency ", tag}, lat, 80);
    exp_v = model(s, scale);
    got = d_limit_o;
    check(longint'(got) == exp_v, {"R2 R4 R5 value ", tag}, got, exp_v);
    @(negedge clk);
    check(d_limit_vld_o == 1'b0, {"R8 pulse width ", tag}, d_limit_vld_o, 0);
    repeat (5) @(negedge clk);
    check(d_limit_o == got, {"R8 hold ", tag}, d_limit_o, got);
  endtask

  task automatic t_nominal();   run_window(0, 8000, 10000, 3000, 2000, 327, "nominal"); endtask
  task automatic t_ramp();      run_window(1, 1000, 20000, -500, 4000, 500, "ramp"); endtask
  task automatic t_negative();  run_window(0, 10000, -10000, 0, 0, 40000, "R6 negative"); endtask
  task automatic t_saturate();
    run_window(0, 30000, 30000, 30000, 30000, 65535, "R7 saturate");
    check(d_limit_o == 16'd32768, "R7 half clamp", d_limit_o, 32768);
  endtask
  task automatic t_low();       run_window(0, 1000, 1000, 0, 0, 20000, "low"); endtask
  task automatic t_zero_pu();
    run_window(0, 10, 10, 0, 0, 1, "R7 zero power");
    check(d_limit_o == 16'd0, "R7 zero clamp", d_limit_o, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    smp_stb_i = 1'b0;
    id_i = '0; iq_i = '0; vd_i = '0; vq_i = '0;
    pu_scale_i = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_nominal();
    t_saturate();
    t_ramp();
    t_negative();
    t_low();
    t_zero_pu();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule